// File: doc/BRIEF.md
# Freeze Bridge Controller

This block fences off a reconfigurable logic region while the region is rebuilt. Software drives it through four 32-bit word registers on a simple request bus. Writing a freeze request raises the freeze output toward the region. The controller then waits until the region reports that it is idle, and only after that does it flag the freeze as done. While the region is frozen, software can hold it in reset. An unfreeze request lifts the region reset first, lowers freeze in the next cycle, and reports the unfreeze as done one cycle after that.

Software learns the progress of each phase from two done flags in the status word. A request that arrives in a state where it makes no sense is not carried out. Instead it sets a sticky cause bit, which software clears by writing a one. A request that asks for the phase already reached is dropped without any trace. A constant version word lets software identify the block.

Top module: `frz_bridge_ctl`

## Requirements
- R1: Word index 0 (byte offset 0) reads status, 1 (offset 4) control, 2 (offset 8) illegal-cause, 3 (offset 12) version. The version word reads the constant 2. Read data appears on rdata_o with rvalid_o high in the cycle after the read request is sampled.
- R2: After reset the status word reads 2, with unfreeze-done at bit 1 set and freeze-done at bit 0 clear. freeze_o and region_rst_o are 0, and the illegal-cause and control words read 0.
- R3: A control write with bit 0 set, accepted while unfreeze-done is set, raises freeze_o from the next cycle and clears both done flags (status reads 0). Status stays 0 for as long as region_idle_i is low. Freeze-done sets in the cycle after region_idle_i is sampled high while freeze_o is high.
- R4: While frozen, a control write with bit 1 set (and bit 2 clear) raises region_rst_o. A later control write with bit 1 clear lowers it. region_rst_o is never high while freeze_o is low.
- R5: A control write with bit 2 set, accepted while frozen, lowers region_rst_o in the next cycle while freeze_o stays high. freeze_o falls one cycle later. Unfreeze-done sets, and freeze-done clears, one cycle after both outputs are low.
- R6: A freeze request while freeze-done is set, or an unfreeze request while unfreeze-done is set, changes neither the status nor the illegal-cause word.
- R7: A freeze request while neither done flag is set sets illegal-cause bit 0 and has no other effect.
- R8: An unfreeze request while neither done flag is set sets illegal-cause bit 1 and has no other effect.
- R9: A reset request (control bit 1) outside the frozen state sets illegal-cause bit 2 and leaves region_rst_o low.
- R10: Illegal-cause bits are sticky. A write to the illegal-cause word with bit 0 set clears all of them. A write there with bit 0 clear leaves them unchanged.
- R11: The two status done flags are never set at the same time.
- R12: The control word reads back bits [2:0] of the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address; bits [1:0] ignored |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, registered |
| rvalid_o | output | 1 | Read data valid |
| region_idle_i | input | 1 | Region reports it is idle |
| freeze_o | output | 1 | Freeze toward the region |
| region_rst_o | output | 1 | Reset toward the region |

## Verification
The bound checker watches a set of rules on every cycle:
- the two done flags never both set;
- region reset only under freeze;
- a done flag rising only after its precondition on the pins held in the cycle before;
- illegal-cause bits never dropping without a clear write;
- the version word reading 2.

Other behaviour shows only in the bench's register-level scenarios:
- the exact cycle spacing of the unfreeze sequence;
- redundant requests leaving no trace;
- each out-of-order request setting its own cause bit;
- control readback.

// File: rtl/frz_pkg.sv
package frz_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_FRZ_WAIT,
    ST_FROZEN,
    ST_REL_RST,
    ST_REL_FRZ
  } frz_state_e;

  localparam int unsigned NUM_REGS   = 4;
  localparam int unsigned IDX_STATUS = 0;
  localparam int unsigned IDX_CTRL   = 1;
  localparam int unsigned IDX_ILL    = 2;
  localparam int unsigned IDX_VER    = 3;

  // control bits; illegal-cause bits reuse freeze/unfreeze/reset order 0/1/2
  localparam int unsigned B_FRZ   = 0;
  localparam int unsigned B_RST   = 1;
  localparam int unsigned B_UNFRZ = 2;
  localparam int unsigned ILL_FRZ   = 0;
  localparam int unsigned ILL_UNFRZ = 1;
  localparam int unsigned ILL_RST   = 2;
  localparam int unsigned CAUSE_W   = 3;
endpackage

// File: rtl/frz_csr_decode.sv
module frz_csr_decode #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        we_i,
  output logic [frz_pkg::NUM_REGS-1:0] sel_o,
  output logic [frz_pkg::NUM_REGS-1:0] wsel_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  assign idx = addr_i[ADDR_W-1:2];

  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];

  for (genvar k = 0; k < frz_pkg::NUM_REGS; k++) begin : g_sel
    assign sel_o[k]  = (idx == IDX_W'(k));
    assign wsel_o[k] = we_i & sel_o[k];
  end
endmodule

// File: rtl/frz_seq.sv
module frz_seq
  import frz_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic               frz_req_i,
  input  logic               rst_req_i,
  input  logic               unfrz_req_i,
  input  logic               region_idle_i,
  output logic               freeze_o,
  output logic               region_rst_o,
  output logic               frz_done_o,
  output logic               unfrz_done_o,
  output logic [CAUSE_W-1:0] ill_set_o
);
  frz_state_e st_q, st_d;
  logic       rst_hold_q, rst_hold_d;
  logic       frozen;

  assign frozen       = (st_q == ST_FROZEN);
  assign frz_done_o   = (st_q == ST_FROZEN) || (st_q == ST_REL_RST) || (st_q == ST_REL_FRZ);
  assign unfrz_done_o = (st_q == ST_RUN);
  assign freeze_o     = (st_q == ST_FRZ_WAIT) || (st_q == ST_FROZEN) || (st_q == ST_REL_RST);
  assign region_rst_o = rst_hold_q;

  // neither flag set means a freeze is in flight: both directions are out of order
  always_comb begin
    ill_set_o            = '0;
    ill_set_o[ILL_FRZ]   = ctrl_we_i & frz_req_i   & ~frz_done_o & ~unfrz_done_o;
    ill_set_o[ILL_UNFRZ] = ctrl_we_i & unfrz_req_i & ~frz_done_o & ~unfrz_done_o;
    ill_set_o[ILL_RST]   = ctrl_we_i & rst_req_i   & ~frozen;
  end

  always_comb begin
    st_d       = st_q;
    rst_hold_d = 1'b0;
    unique case (st_q)
      ST_RUN:      if (ctrl_we_i && frz_req_i) st_d = ST_FRZ_WAIT;
      ST_FRZ_WAIT: if (region_idle_i) st_d = ST_FROZEN;
      ST_FROZEN: begin
        rst_hold_d = rst_hold_q;
        if (ctrl_we_i) begin
          if (unfrz_req_i) begin
            st_d       = ST_REL_RST;
            rst_hold_d = 1'b0;
          end else begin
            rst_hold_d = rst_req_i;
          end
        end
      end
      ST_REL_RST:  st_d = ST_REL_FRZ;
      ST_REL_FRZ:  st_d = ST_RUN;
      default:     st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_RUN;
      rst_hold_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      rst_hold_q <= rst_hold_d;
    end
  end
endmodule

// File: rtl/frz_cause_reg.sv
module frz_cause_reg #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] mask_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mask_o[b] <= 1'b0;
      else if (clr_i)     mask_o[b] <= 1'b0;
      else if (set_i[b])  mask_o[b] <= 1'b1;
    end
  end
endmodule

// File: rtl/frz_bridge_ctl.sv
module frz_bridge_ctl
  import frz_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned VERSION = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic              region_idle_i,
  output logic              freeze_o,
  output logic              region_rst_o
);
  localparam int unsigned CTRL_W = 3;

  logic [NUM_REGS-1:0] sel, wsel;
  logic [CTRL_W-1:0]   ctrl_q;
  logic [CAUSE_W-1:0]  ill_set, ill_mask;
  logic                frz_done, unfrz_done, ill_clr;
  logic [DATA_W-1:0]   rd_mux;
  logic                unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CTRL_W];

  frz_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .we_i   (we_i),
    .sel_o  (sel),
    .wsel_o (wsel)
  );

  frz_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ctrl_we_i     (wsel[IDX_CTRL]),
    .frz_req_i     (wdata_i[B_FRZ]),
    .rst_req_i     (wdata_i[B_RST]),
    .unfrz_req_i   (wdata_i[B_UNFRZ]),
    .region_idle_i (region_idle_i),
    .freeze_o      (freeze_o),
    .region_rst_o  (region_rst_o),
    .frz_done_o    (frz_done),
    .unfrz_done_o  (unfrz_done),
    .ill_set_o     (ill_set)
  );

  assign ill_clr = wsel[IDX_ILL] & wdata_i[0];

  frz_cause_reg #(.W(CAUSE_W)) u_cause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ill_set),
    .clr_i  (ill_clr),
    .mask_o (ill_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ctrl_q <= '0;
    else if (wsel[IDX_CTRL])  ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (sel[IDX_STATUS]) rd_mux = DATA_W'({unfrz_done, frz_done});
    if (sel[IDX_CTRL])   rd_mux = DATA_W'(ctrl_q);
    if (sel[IDX_ILL])    rd_mux = DATA_W'(ill_mask);
    if (sel[IDX_VER])    rd_mux = DATA_W'(VERSION);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= re_i;
      if (re_i) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/frz_bridge_chk.sv
module frz_bridge_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              re_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              region_idle_i,
  input logic              freeze_o,
  input logic              region_rst_o,
  input logic              frz_done,
  input logic              unfrz_done,
  input logic              ill_clr,
  input logic [2:0]        ill_mask
);
  a_r11_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frz_done && unfrz_done));

  a_r4_rst_under_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    region_rst_o |-> freeze_o);

  a_r3_frz_done_after_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frz_done) |-> $past(freeze_o && region_idle_i));

  a_r5_unfrz_done_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unfrz_done) |-> $past(!freeze_o && !region_rst_o));

  a_r5_unfrozen_outputs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unfrz_done |-> (!freeze_o && !region_rst_o));

  a_r10_cause_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ill_clr) |-> ((ill_mask & $past(ill_mask)) == $past(ill_mask)));

  a_r1_version_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i[ADDR_W-1:2] == 3) |=> (rdata_o == DATA_W'(2)));
endmodule

bind frz_bridge_ctl frz_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .re_i          (re_i),
  .addr_i        (addr_i),
  .rdata_o       (rdata_o),
  .region_idle_i (region_idle_i),
  .freeze_o      (freeze_o),
  .region_rst_o  (region_rst_o),
  .frz_done      (frz_done),
  .unfrz_done    (unfrz_done),
  .ill_clr       (ill_clr),
  .ill_mask      (ill_mask)
);

// File: tb/test_frz_bridge_ctl.sv
module test_frz_bridge_ctl;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              we = 1'b0, re = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              rvalid;
  logic              idle = 1'b0;
  logic              frz, rrst;

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    logic [DATA_W-1:0] val;
    string             tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  frz_bridge_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_frz_bridge_ctl (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .region_idle_i(idle), .freeze_o(frz), .region_rst_o(rrst)
  );

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [DATA_W-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = ADDR_W'(idx * 4); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int idx, logic [DATA_W-1:0] e, string tag);
    exp_t it;
    @(negedge clk);
    re = 1'b1; addr = ADDR_W'(idx * 4);
    it.val = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    re = 1'b0;
  endtask

  // monitor: compare each returned read against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check("unexpected read", 1, 0);
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        check(it.tag, rdata, it.val);
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R2 freeze_o", DATA_W'(frz), 0);
    check("R2 region_rst_o", DATA_W'(rrst), 0);
    rd(3, 2, "R1 version");
    rd(0, 2, "R2 status");
    rd(2, 0, "R2 illegal");
    rd(1, 0, "R2 ctrl");

    // redundant unfreeze
    wr(1, 4);
    rd(2, 0, "R6 unfreeze redundant illegal");
    rd(0, 2, "R6 unfreeze redundant status");

    // reset while unfrozen
    wr(1, 2);
    check("R9 region_rst_o", DATA_W'(rrst), 0);
    rd(2, 4, "R9 illegal reset bit");
    wr(2, 0);
    rd(2, 4, "R10 write zero keeps");
    wr(2, 1);
    rd(2, 0, "R10 clear");

    // freeze, region busy
    wr(1, 1);
    check("R3 freeze_o raised", DATA_W'(frz), 1);
    rd(0, 0, "R3 status while waiting");
    repeat (5) @(negedge clk);
    rd(0, 0, "R3 status still waiting");
    wr(1, 1);
    rd(2, 1, "R7 freeze while freezing");
    wr(1, 4);
    rd(2, 3, "R8 unfreeze while freezing");
    rd(1, 4, "R12 ctrl readback");
    rd(0, 0, "R7 status unchanged");
    check("R8 freeze_o held", DATA_W'(frz), 1);

    // region acknowledges
    @(negedge clk); idle = 1'b1;
    @(negedge clk); idle = 1'b0;
    rd(0, 1, "R3 freeze done");

    wr(2, 1);
    wr(1, 1);
    rd(2, 0, "R6 freeze redundant illegal");
    rd(0, 1, "R6 freeze redundant status");

    // hold in reset, release, hold again
    wr(1, 2);
    check("R4 region_rst_o set", DATA_W'(rrst), 1);
    rd(1, 2, "R12 ctrl readback reset");
    wr(1, 0);
    check("R4 region_rst_o released", DATA_W'(rrst), 0);
    wr(1, 2);
    check("R4 region_rst_o set again", DATA_W'(rrst), 1);

    // unfreeze sequence
    wr(1, 4);
    check("R5 rst low first", DATA_W'(rrst), 0);
    check("R5 freeze still high", DATA_W'(frz), 1);
    @(negedge clk);
    check("R5 freeze falls", DATA_W'(frz), 0);
    @(negedge clk);
    rd(0, 2, "R5 unfreeze done");
    rd(2, 0, "R5 no illegal");

    repeat (3) @(negedge clk);
    check("scoreboard drained", DATA_W'(exp_q.size()), 0);
    finish_run();
  end
endmodule